// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This controller runs the refill of one cache line after a miss. It takes a miss (line address, offset of the missed word and a fetch-order mode), issues one memory read per word of the line, and writes each returned word into a line buffer. The word the processor is waiting for is passed to the processor as soon as it comes back, one cycle after its response is accepted. The rest of the line keeps filling behind it. When the last word has been written, a one-cycle line-complete pulse is raised. After that pulse the controller accepts the next miss.

Two fetch orders are offered. In wrap-around order the missed word is requested first and the offsets climb from there, wrapping past the last word back to word 0. In sequential order the words are requested from word 0 upward, and the missed word is still forwarded the moment it arrives. Memory responses carry no offset. They come back in request order, and the controller works out by itself which word each response belongs to. Only one miss is handled at a time.

Top module: `cwf_refill_ctrl`

## Requirements
- R1: After reset, miss_ready is 1 and mem_req_valid, fwd_valid and line_done are 0.
- R2: With miss_mode = 0 (wrap-around), the word offsets requested are off, off+1, ... modulo WORDS, where off is the missed offset. For example, offset 2 of 4 gives 2,3,0,1. Each mem_req_addr is {line address, word offset}, with the offset in the low log2(WORDS) bits.
- R3: With miss_mode = 1 (sequential), the word offsets requested are 0,1,...,WORDS-1 in that order, whatever the missed offset.
- R4: Exactly WORDS requests are accepted per miss. While mem_req_valid is high and mem_req_ready is low, the request address holds steady.
- R5: fwd_valid is high for exactly one cycle per miss. That cycle is the one after the edge that accepted the response for the missed word, and fwd_data then equals that response's data.
- R6: Responses are matched to word offsets in the order the requests were issued. When line_done is high, word i of line_data (bits i*WORD_W upward) holds the data returned for offset i.
- R7: line_done is high for exactly one cycle per miss. That cycle is the one after the edge that accepted the last response of the line.
- R8: miss_ready is 0 from the acceptance of a miss through the line_done cycle, and returns to 1 in the following cycle. A miss_valid presented while miss_ready is 0 is not taken.
- R9: The line address, offset and mode are sampled when the miss is accepted. Changing the miss inputs during the refill does not alter the requests or the forwarded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented |
| miss_ready | output | 1 | Controller is idle and takes a presented miss |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_offset | input | log2(WORDS) | Offset of the missed word within the line |
| miss_mode | input | 1 | 0 = wrap-around order, 1 = sequential order |
| mem_req_valid | output | 1 | Word read request pending |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_addr | output | LINE_AW+log2(WORDS) | Word address of the request |
| mem_rsp_valid | input | 1 | Read data returned, in request order |
| mem_rsp_data | input | WORD_W | Returned word |
| fwd_valid | output | 1 | One-cycle pulse: missed word delivered |
| fwd_data | output | WORD_W | The missed word |
| line_done | output | 1 | One-cycle pulse: whole line written |
| line_data | output | WORDS*WORD_W | Line buffer contents, word i at bits i*WORD_W |

## Verification
On every cycle the assertions check these points: a stalled request address holds steady, no more than WORDS requests are taken per miss, fwd_valid and line_done last one cycle, exactly one forward happens before or with line completion, requests appear only while busy, and requests carry the sampled line address. Only the bench's scenarios can show the rest. These are the exact order of requested offsets in each mode, which word gets forwarded and with which data, the one-cycle placement of forward and completion after their responses, and the contents of the finished line. The scenarios run under random memory stalls and latencies, and some hold junk on the miss inputs during the refill.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    typedef enum logic {
        MODE_WRAP = 1'b0,
        MODE_SEQ  = 1'b1
    } fetch_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_DONE = 2'd2
    } refill_state_e;

    // Slot reached after 'step' words starting from 'base', modulo 'words'.
    // base < words and step <= words, so one conditional subtract suffices.
    function automatic int unsigned wrap_slot(input int unsigned base,
                                              input int unsigned step,
                                              input int unsigned words);
        int unsigned sum;
        sum = base + step;
        if (sum >= words) sum = sum - words;
        return sum;
    endfunction

endpackage

// File: rtl/cwf_fetch_seq.sv
module cwf_fetch_seq #(
    parameter int WORDS = 4,
    localparam int OFF_W = $clog2(WORDS),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [OFF_W-1:0] base_off,
    input  logic             advance,
    output logic [OFF_W-1:0] cur_off,
    output logic             last,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (advance && !done) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        cur_off = OFF_W'(cwf_pkg::wrap_slot(32'(base_off), 32'(cnt), WORDS));
        last    = (cnt == CNT_W'(WORDS - 1));
        done    = (cnt == CNT_W'(WORDS));
    end
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    output logic [WORDS*WORD_W-1:0] line_out
);
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en && (wr_idx == OFF_W'(i))) begin
                word_q <= wr_data;
            end
        end
        assign line_out[i*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/cwf_fwd_unit.sv
module cwf_fwd_unit #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rsp_fire,
    input  logic [OFF_W-1:0]  rsp_idx,
    input  logic [OFF_W-1:0]  want_idx,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              fwd_valid,
    output logic [WORD_W-1:0] fwd_data
);
    logic hit;
    assign hit = rsp_fire && (rsp_idx == want_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid <= 1'b0;
            fwd_data  <= '0;
        end else begin
            fwd_valid <= hit;
            if (hit) fwd_data <= rsp_data;
        end
    end
endmodule

// File: rtl/cwf_refill_ctrl.sv
module cwf_refill_ctrl
    import cwf_pkg::*;
#(
    parameter int LINE_AW = 26,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 4,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int ADDR_W = LINE_AW + OFF_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    miss_valid,
    output logic                    miss_ready,
    input  logic [LINE_AW-1:0]      miss_line,
    input  logic [OFF_W-1:0]        miss_offset,
    input  logic                    miss_mode,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [ADDR_W-1:0]       mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [WORD_W-1:0]       mem_rsp_data,
    output logic                    fwd_valid,
    output logic [WORD_W-1:0]       fwd_data,
    output logic                    line_done,
    output logic [WORDS*WORD_W-1:0] line_data
);
    typedef struct packed {
        logic [LINE_AW-1:0] line;
        logic [OFF_W-1:0]   want;
        logic [OFF_W-1:0]   first;
        fetch_mode_e        mode;
    } miss_ctx_t;

    refill_state_e state_q, state_d;
    miss_ctx_t     ctx_q;

    logic             accept;
    logic             req_fire;
    logic             rsp_fire;
    logic [OFF_W-1:0] req_off, rsp_off;
    logic             req_last, req_done;
    logic             rsp_last, rsp_done;

    assign miss_ready = (state_q == ST_IDLE);
    assign accept     = miss_valid && miss_ready;

    // Miss context: captured once, held for the whole refill.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (accept) begin
            ctx_q.line  <= miss_line;
            ctx_q.want  <= miss_offset;
            ctx_q.mode  <= fetch_mode_e'(miss_mode);
            ctx_q.first <= (fetch_mode_e'(miss_mode) == MODE_WRAP) ? miss_offset : '0;
        end
    end

    // Sequencing FSM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_FILL;
            ST_FILL: if (rsp_fire && rsp_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign mem_req_valid = (state_q == ST_FILL) && !req_done;
    assign req_fire      = mem_req_valid && mem_req_ready;
    assign mem_req_addr  = {ctx_q.line, req_off};
    assign rsp_fire      = (state_q == ST_FILL) && mem_rsp_valid && !rsp_done;
    assign line_done     = (state_q == ST_DONE);

    // Request side: walks the fetch order as memory takes requests.
    cwf_fetch_seq #(.WORDS(WORDS)) u_req_seq (
        .clk      (clk),
        .rst      (rst),
        .restart  (accept),
        .base_off (accept ? ((fetch_mode_e'(miss_mode) == MODE_WRAP) ? miss_offset : '0)
                          : ctx_q.first),
        .advance  (req_fire),
        .cur_off  (req_off),
        .last     (req_last),
        .done     (req_done)
    );

    // Response side: same order, advanced by returned words.
    cwf_fetch_seq #(.WORDS(WORDS)) u_rsp_seq (
        .clk      (clk),
        .rst      (rst),
        .restart  (accept),
        .base_off (ctx_q.first),
        .advance  (rsp_fire),
        .cur_off  (rsp_off),
        .last     (rsp_last),
        .done     (rsp_done)
    );

    cwf_line_buf #(.WORDS(WORDS), .WORD_W(WORD_W)) u_line_buf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (rsp_fire),
        .wr_idx   (rsp_off),
        .wr_data  (mem_rsp_data),
        .line_out (line_data)
    );

    cwf_fwd_unit #(.WORDS(WORDS), .WORD_W(WORD_W)) u_fwd (
        .clk       (clk),
        .rst       (rst),
        .rsp_fire  (rsp_fire),
        .rsp_idx   (rsp_off),
        .want_idx  (ctx_q.want),
        .rsp_data  (mem_rsp_data),
        .fwd_valid (fwd_valid),
        .fwd_data  (fwd_data)
    );

    logic unused_ok;
    assign unused_ok = &{1'b0, req_last};
endmodule

// File: rtl/cwf_refill_checker.sv
module cwf_refill_checker #(
    parameter int LINE_AW = 26,
    parameter int WORDS   = 4,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int ADDR_W = LINE_AW + OFF_W
) (
    input logic               clk,
    input logic               rst,
    input logic               miss_valid,
    input logic               miss_ready,
    input logic [LINE_AW-1:0] miss_line,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic               fwd_valid,
    input logic               line_done
);
    logic [7:0]         issued;
    logic [7:0]         fwds;
    logic [LINE_AW-1:0] line_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            issued    <= '0;
            fwds      <= '0;
            line_seen <= '0;
        end else if (miss_valid && miss_ready) begin
            issued    <= '0;
            fwds      <= '0;
            line_seen <= miss_line;
        end else begin
            if (mem_req_valid && mem_req_ready) issued <= issued + 8'd1;
            if (fwd_valid) fwds <= fwds + 8'd1;
        end
    end

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_req_count_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |-> (32'(issued) < WORDS));

    assert_fwd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |=> !fwd_valid);

    assert_fwd_once_R5: assert property (@(posedge clk) disable iff (rst)
        line_done |-> ((32'(fwds) + (fwd_valid ? 1 : 0)) == 1));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        line_done |=> (!line_done && miss_ready));

    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || line_done) |-> !miss_ready);

    assert_line_kept_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (mem_req_addr[ADDR_W-1:OFF_W] == line_seen));
endmodule

bind cwf_refill_ctrl cwf_refill_checker #(.LINE_AW(LINE_AW), .WORDS(WORDS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .miss_line     (miss_line),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .fwd_valid     (fwd_valid),
    .line_done     (line_done)
);

// File: tb/cwf_refill_ctrl_test.sv
module cwf_refill_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_AW = 26;
    localparam int WORD_W  = 32;
    localparam int WORDS   = 4;
    localparam int OFF_W   = 2;
    localparam int ADDR_W  = LINE_AW + OFF_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic miss_valid = 1'b0;
    logic miss_ready;
    logic [LINE_AW-1:0] miss_line = '0;
    logic [OFF_W-1:0]   miss_offset = '0;
    logic miss_mode = 1'b0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [WORD_W-1:0] mem_rsp_data = '0;
    logic fwd_valid;
    logic [WORD_W-1:0] fwd_data;
    logic line_done;
    logic [WORDS*WORD_W-1:0] line_data;

    cwf_refill_ctrl #(.LINE_AW(LINE_AW), .WORD_W(WORD_W), .WORDS(WORDS)) uut (
        .clk(clk), .rst(rst),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_line(miss_line), .miss_offset(miss_offset), .miss_mode(miss_mode),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .line_done(line_done), .line_data(line_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Memory model and per-miss observations
    logic [ADDR_W-1:0] pend_q[$];
    logic [ADDR_W-1:0] req_log[$];
    int n = 0;
    int fast = 0;
    int cur_want = 0;
    int rsp_total, crit_n, last_n;
    int fwd_cnt, fwd_n, done_cnt, done_n;
    logic [WORD_W-1:0] fwd_seen;
    logic [WORDS*WORD_W-1:0] line_seen;
    logic ready_at_done;

    function automatic logic [WORD_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic int exp_off(input int want, input int mode, input int i);
        if (mode == 0) return (want + i) % WORDS;
        return i;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        n++;
        if (fwd_valid) begin
            fwd_cnt++;
            fwd_n = n;
            fwd_seen = fwd_data;
        end
        if (line_done) begin
            done_cnt++;
            done_n = n;
            line_seen = line_data;
            ready_at_done = miss_ready;
            miss_valid = 1'b0;
        end
        mem_rsp_valid = 1'b0;
        if (pend_q.size() > 0 && (fast != 0 || ($urandom % 4) != 0)) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = mem_word(pend_q[0]);
            rsp_total++;
            if (int'(pend_q[0][OFF_W-1:0]) == cur_want) crit_n = n;
            if (rsp_total == WORDS) last_n = n;
            void'(pend_q.pop_front());
        end
        mem_req_ready = (fast != 0) ? 1'b1 : (($urandom % 3) != 0);
        if (mem_req_valid && mem_req_ready) begin
            req_log.push_back(mem_req_addr);
            pend_q.push_back(mem_req_addr);
        end
    endtask

    task automatic run_miss(input logic [LINE_AW-1:0] line, input int want,
                            input int mode, input bit junk);
        int guard;
        string oreq;
        bit all_ok;
        oreq = (mode == 0) ? "R2" : "R3";
        req_log.delete();
        rsp_total = 0; crit_n = -100; last_n = -100;
        fwd_cnt = 0; fwd_n = -1; done_cnt = 0; done_n = -1;
        cur_want = want;
        guard = 0;
        while (!miss_ready && guard < 50) begin step(); guard++; end
        miss_valid  = 1'b1;
        miss_line   = line;
        miss_offset = OFF_W'(want);
        miss_mode   = mode[0];
        step();
        miss_valid = junk;
        if (junk) begin
            miss_line   = ~line;
            miss_offset = OFF_W'(want + 1);
            miss_mode   = ~mode[0];
        end
        guard = 0;
        while (done_cnt == 0 && guard < 300) begin
            step();
            if (junk && done_cnt == 0) miss_offset = OFF_W'($urandom);
            guard++;
        end
        check(done_cnt == 1, "R7", "line_done count", done_cnt, 1);
        step();
        check(miss_ready == 1'b1, "R8", "ready after done", miss_ready, 1);
        check(ready_at_done == 1'b0, "R8", "ready during done", ready_at_done, 0);
        step();
        check(done_cnt == 1, "R7", "line_done pulse width", done_cnt, 1);
        check(req_log.size() == WORDS, "R4", "request count", req_log.size(), WORDS);
        all_ok = 1'b1;
        for (int i = 0; i < req_log.size() && i < WORDS; i++) begin
            logic [ADDR_W-1:0] e;
            e = {line, OFF_W'(exp_off(want, mode, i))};
            if (req_log[i] != e) begin
                all_ok = 1'b0;
                check(1'b0, oreq, "request address", req_log[i], e);
            end
        end
        if (all_ok) check(1'b1, oreq, "request order", 0, 0);
        if (junk) check(all_ok && req_log.size() == WORDS, "R9", "requests with junk inputs", 0, 0);
        check(fwd_cnt == 1, "R5", "forward count", fwd_cnt, 1);
        check(fwd_seen == mem_word({line, OFF_W'(want)}), junk ? "R9" : "R5",
              "forward data", fwd_seen, mem_word({line, OFF_W'(want)}));
        check(fwd_n == crit_n + 1, "R5", "forward timing", fwd_n, crit_n + 1);
        check(done_n == last_n + 1, "R7", "done timing", done_n, last_n + 1);
        for (int i = 0; i < WORDS; i++) begin
            logic [WORD_W-1:0] w;
            w = line_seen[i*WORD_W +: WORD_W];
            check(w == mem_word({line, OFF_W'(i)}), "R6", "line word", w,
                  mem_word({line, OFF_W'(i)}));
        end
    endtask

    initial begin
        void'($urandom(32'd7315));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        // R1: reset state
        check(miss_ready == 1'b1, "R1", "miss_ready", miss_ready, 1);
        check(mem_req_valid == 1'b0, "R1", "mem_req_valid", mem_req_valid, 0);
        check(fwd_valid == 1'b0, "R1", "fwd_valid", fwd_valid, 0);
        check(line_done == 1'b0, "R1", "line_done", line_done, 0);

        // Directed corners: both modes, first/last offsets, fast and slow memory
        fast = 1;
        run_miss(26'h0000123, 2, 0, 1'b0);
        run_miss(26'h3FFFFFF, 3, 0, 1'b0);
        run_miss(26'h0000000, 0, 1, 1'b0);
        run_miss(26'h1555555, 3, 1, 1'b1);
        fast = 0;
        run_miss(26'h2AAAAAA, 0, 0, 1'b1);
        run_miss(26'h0101010, 2, 1, 1'b0);

        // Random
        for (int k = 0; k < 40; k++) begin
            fast = (($urandom % 5) == 0) ? 1 : 0;
            run_miss(LINE_AW'($urandom), int'($urandom % WORDS), int'($urandom % 2),
                     1'(($urandom % 2)));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule